// File: doc/BRIEF.md
# Polled Interrupt Controller

This block collects a set of interrupt request lines, latches a request on each rising edge and picks one winning source by fixed priority. It serves software that handles interrupts by polling instead of by hardware vectoring. Software reaches it through a small register bus with four word addresses. Two of them return the same pending-interrupt word. Reading the acknowledging view (address 0) takes the winner out of the request set and marks it in service, exactly as a hardware acknowledge would. Reading the inspecting view (address 1) changes nothing. No vector is fetched. The reader gets the interrupt type and runs the routine itself.

A per-source mask (address 2) hides sources from arbitration. A write to the end-of-interrupt address (address 3) retires the highest-priority source in service. The lowest-numbered source has the highest priority. A source in service blocks itself and every lower-priority source until it is retired.

Bus accesses are tracked by a small state machine whose state names the kind of access taken at the previous edge:

- ST_IDLE: no access.
- ST_POLL_RSP: acknowledging read.
- ST_STAT_RSP: inspecting read.
- ST_MASK_RSP: mask read, or a read of address 3.
- ST_WR_DONE: any write.

Every state moves on each clock edge to the state that matches the strobe seen at that edge. A read goes to the state for its address. A write goes to ST_WR_DONE. No strobe goes to ST_IDLE.

Top module: `pollint_ctrl`

## Requirements
- R1: After reset, bus_rvalid is 0. The request, in-service and mask state are all clear, so the status and mask reads both return 0.
- R2: A rising edge on irq_in[i] latches request i at the next clock edge. A line held high after its request was acknowledged does not latch again until it goes low and rises again.
- R3: The pending word has bit 15 set when an interrupt is pending, bits 4:0 holding TYPE_BASE+i for the winning source i, and every other bit 0 (default TYPE_BASE is 8).
- R4: A read of address 1 returns the pending word and changes no request, in-service or mask state. Repeated reads return the same value.
- R5: A read of address 0 returns the pending word. At the same clock edge it clears the winner's request and sets its in-service bit.
- R6: A read of address 0 with nothing pending returns 0 and changes no state.
- R7: Priority is fixed, with the lowest index winning. An in-service source blocks its own index and all higher indices, while lower indices still win.
- R8: Any write to address 3 clears the lowest-indexed set in-service bit.
- R9: Mask bit i (write address 2, data bits NUM_SRC-1:0) removes source i from arbitration and from bit 15. The request stays latched and appears once the bit is cleared. Reading address 2 returns the mask in bits NUM_SRC-1:0 and zeros above.
- R10: bus_rvalid is 1, and bus_rdata carries the read value, exactly in the cycle after a read strobe. At all other times bus_rvalid is 0 and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Interrupt request lines, rising-edge latched |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, ignored when bus_rd is high |
| bus_addr | input | 2 | 0 acknowledge, 1 status, 2 mask, 3 end of interrupt |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |

## Verification
A request is visible one edge after its input rises. Bus strobes are applied for one cycle between edges. The read result is registered at the edge that ends the strobe, together with the acknowledge, mask and end-of-interrupt updates, so every read and its side effects are due one cycle after the strobe. The bench drives on the falling edge and samples bus_rdata and bus_rvalid 1 ns after the following rising edge. It confirms each side effect with a separate status or mask read made afterwards, and checks one cycle later that bus_rvalid and bus_rdata have returned to 0.

// File: rtl/pollint_pkg.sv
package pollint_pkg;

    localparam int BUS_W = 16;
    localparam int TYPE_W = 5;

    localparam logic [1:0] ADDR_POLL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_EOI  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_POLL_RSP = 3'd1,
        ST_STAT_RSP = 3'd2,
        ST_MASK_RSP = 3'd3,
        ST_WR_DONE  = 3'd4
    } bus_state_e;

    function automatic logic [BUS_W-1:0] pending_word(input logic flag, input logic [TYPE_W-1:0] ty);
        logic [BUS_W-1:0] w;
        w = '0;
        if (flag) begin
            w[BUS_W-1]    = 1'b1;
            w[TYPE_W-1:0] = ty;
        end
        return w;
    endfunction

endpackage

// File: rtl/pollint_req_latch.sv
module pollint_req_latch #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] ack_clr,
    output logic [NUM_SRC-1:0] req_q
);

    logic [NUM_SRC-1:0] irq_prev_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = irq_in & ~irq_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prev_q <= '0;
            req_q      <= '0;
        end else begin
            irq_prev_q <= irq_in;
            req_q      <= (req_q & ~ack_clr) | rise;
        end
    end

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr != '0) && ((ack_clr & rise) == '0) |=> ((req_q & $past(ack_clr)) == '0)); // R5

    AST_REQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) or ((req_q & ~$past(req_q)) == '0) or ((req_q & ~$past(req_q) & $past(irq_prev_q)) == '0)); // R2

endmodule

// File: rtl/pollint_prio.sv
module pollint_prio #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] isr_q,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [NUM_SRC-1:0] win_onehot
);

    logic [NUM_SRC-1:0] blocked;
    logic [NUM_SRC-1:0] cand;

    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            seen       = seen | isr_q[i];
            blocked[i] = seen;
        end
    end

    assign cand = req_q & ~mask_q & ~blocked;

    always_comb begin
        win_valid  = 1'b0;
        win_idx    = '0;
        win_onehot = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win_valid  = 1'b1;
                win_idx    = IDX_W'(i);
                win_onehot = NUM_SRC'(1) << i;
            end
        end
    end

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_onehot) && (win_valid == (win_onehot != '0))); // R3

    AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (win_onehot & (mask_q | ~req_q)) == '0); // R9

    AST_WIN_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (((win_onehot - NUM_SRC'(1)) | win_onehot) & isr_q & {NUM_SRC{win_valid}}) == '0); // R7

endmodule

// File: rtl/pollint_isr.sv
module pollint_isr #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_onehot,
    input  logic               eoi_en,
    output logic [NUM_SRC-1:0] isr_q
);

    logic [NUM_SRC-1:0] eoi_clr;

    always_comb begin
        eoi_clr = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (isr_q[i]) eoi_clr = NUM_SRC'(1) << i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~(eoi_en ? eoi_clr : '0)) | set_onehot;
        end
    end

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_en && (set_onehot == '0) && (isr_q != '0) |=>
            ($countones(isr_q) + 1 == $countones($past(isr_q))) && ((isr_q & ~$past(isr_q)) == '0)); // R8

    AST_EOI_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_en && (set_onehot == '0) && (isr_q != '0) |=>
            ((($past(isr_q) & ~isr_q) - NUM_SRC'(1)) & $past(isr_q)) == '0); // R8

endmodule

// File: rtl/pollint_ctrl.sv
module pollint_ctrl
    import pollint_pkg::*;
#(
    parameter int          NUM_SRC   = 8,
    parameter logic [4:0]  TYPE_BASE = 5'd8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic               bus_rvalid
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    bus_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] req_q, mask_q, isr_q;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [NUM_SRC-1:0] win_onehot;
    logic [BUS_W-1:0]   poll_word, snap_d, snap_q;
    logic               ack_fire, eoi_fire, mask_fire;
    logic [NUM_SRC-1:0] ack_vec;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;

    pollint_req_latch #(.NUM_SRC(NUM_SRC)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .ack_clr (ack_vec),
        .req_q   (req_q)
    );

    pollint_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_q      (req_q),
        .mask_q     (mask_q),
        .isr_q      (isr_q),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_onehot (win_onehot)
    );

    pollint_isr #(.NUM_SRC(NUM_SRC)) u_isr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_onehot (ack_vec),
        .eoi_en     (eoi_fire),
        .isr_q      (isr_q)
    );

    assign poll_word = pending_word(win_valid, TYPE_BASE + TYPE_W'(win_idx));
    assign ack_fire  = bus_rd && (bus_addr == ADDR_POLL) && win_valid;
    assign ack_vec   = ack_fire ? win_onehot : '0;
    assign eoi_fire  = !bus_rd && bus_wr && (bus_addr == ADDR_EOI);
    assign mask_fire = !bus_rd && bus_wr && (bus_addr == ADDR_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_fire) begin
            mask_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        snap_d = '0;
        unique case (bus_addr)
            ADDR_POLL: snap_d = poll_word;
            ADDR_STAT: snap_d = poll_word;
            ADDR_MASK: snap_d[NUM_SRC-1:0] = mask_q;
            ADDR_EOI:  snap_d = '0;
            default:   snap_d = '0;
        endcase
    end

    always_comb begin
        state_d = ST_IDLE;
        if (bus_rd) begin
            unique case (bus_addr)
                ADDR_POLL: state_d = ST_POLL_RSP;
                ADDR_STAT: state_d = ST_STAT_RSP;
                default:   state_d = ST_MASK_RSP;
            endcase
        end else if (bus_wr) begin
            state_d = ST_WR_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            snap_q  <= bus_rd ? snap_d : '0;
        end
    end

    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_POLL_RSP, ST_STAT_RSP, ST_MASK_RSP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = snap_q;
            end
            ST_IDLE, ST_WR_DONE: begin
                bus_rvalid = 1'b0;
                bus_rdata  = '0;
            end
            default: begin
                bus_rvalid = 1'b0;
                bus_rdata  = '0;
            end
        endcase
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid); // R10

    AST_QUIET_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid && (bus_rdata == '0)); // R10

    AST_STATUS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == ADDR_STAT) |=> $stable(isr_q) && $stable(mask_q)); // R4

    AST_EMPTY_POLL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == ADDR_POLL) && !win_valid |=>
            $stable(isr_q) && $stable(mask_q) && (bus_rdata == '0)); // R6

    AST_POLL_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> ((isr_q & $past(win_onehot)) == $past(win_onehot)) && bus_rdata[15]); // R5

endmodule

// File: tb/pollint_ctrl_tb.sv
`timescale 1ns/1ps
module pollint_ctrl_tb_top;

    localparam int NSRC = 8;
    localparam time TCLK = 4ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata;
    logic            bus_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    pollint_ctrl #(.NUM_SRC(NSRC), .TYPE_BASE(5'd8)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    function automatic logic [15:0] word_for(input int src);
        return 16'h8000 | 16'(8 + src);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] addr, output logic [15:0] data, output logic vld);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = addr;
        @(posedge clk); #1;
        data = bus_rdata; vld = bus_rvalid;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] addr, input logic [15:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] lines);
        @(negedge clk);
        irq_in = irq_in | lines;
        @(negedge clk);
        irq_in = irq_in & ~lines;
    endtask

    task automatic expect_read(input logic [1:0] addr, input logic [15:0] exp, input string req);
        logic [15:0] d; logic v;
        bus_read(addr, d, v);
        check(v === 1'b1 && d === exp, req, d, exp);
    endtask

    task automatic t_reset;
        #1;
        check(bus_rvalid === 1'b0 && bus_rdata === 16'h0, "R1 idle outputs", bus_rdata, 16'h0);
        expect_read(2'd1, 16'h0000, "R1 status after reset");
        expect_read(2'd2, 16'h0000, "R1 mask after reset");
    endtask

    task automatic t_rvalid_window;
        logic [15:0] d; logic v;
        bus_read(2'd1, d, v);
        check(v === 1'b1, "R10 rvalid after strobe", 16'(v), 16'h1);
        @(posedge clk); #1;
        check(bus_rvalid === 1'b0 && bus_rdata === 16'h0, "R10 quiet next cycle", bus_rdata, 16'h0);
    endtask

    task automatic t_single;
        pulse(8'h08);
        expect_read(2'd1, word_for(3), "R2 R3 status after edge");
        expect_read(2'd0, word_for(3), "R5 poll returns source 3");
        expect_read(2'd1, 16'h0000, "R5 request cleared, in service");
        bus_write(2'd3, 16'h0);
        expect_read(2'd1, 16'h0000, "R8 nothing left after EOI");
    endtask

    task automatic t_priority;
        pulse(8'h24);
        expect_read(2'd0, word_for(2), "R7 lowest index wins");
        expect_read(2'd1, 16'h0000, "R7 in-service 2 blocks 5");
        bus_write(2'd3, 16'h0);
        expect_read(2'd1, word_for(5), "R8 EOI releases source 5");
        expect_read(2'd0, word_for(5), "R5 poll source 5");
        bus_write(2'd3, 16'h0);
    endtask

    task automatic t_nesting;
        pulse(8'h40);
        expect_read(2'd0, word_for(6), "R5 poll source 6");
        pulse(8'h02);
        expect_read(2'd1, word_for(1), "R7 higher priority beats service 6");
        expect_read(2'd0, word_for(1), "R5 nested poll source 1");
        bus_write(2'd3, 16'h0);
        expect_read(2'd1, 16'h0000, "R8 EOI retired 1, 6 still blocks");
        pulse(8'h80);
        expect_read(2'd1, 16'h0000, "R7 source 7 blocked by 6");
        bus_write(2'd3, 16'h0);
        expect_read(2'd1, word_for(7), "R8 EOI retired 6");
        expect_read(2'd0, word_for(7), "R5 poll source 7");
        bus_write(2'd3, 16'h0);
    endtask

    task automatic t_empty_poll;
        expect_read(2'd0, 16'h0000, "R6 empty poll returns 0");
        pulse(8'h01);
        expect_read(2'd0, word_for(0), "R6 state unchanged by empty poll");
        bus_write(2'd3, 16'h0);
    endtask

    task automatic t_status_noside;
        pulse(8'h04);
        expect_read(2'd1, word_for(2), "R4 first status");
        expect_read(2'd1, word_for(2), "R4 repeated status same");
        expect_read(2'd0, word_for(2), "R4 poll still acknowledges");
        bus_write(2'd3, 16'h0);
        expect_read(2'd1, 16'h0000, "R4 clean after EOI");
    endtask

    task automatic t_mask;
        bus_write(2'd2, 16'hFF08);
        expect_read(2'd2, 16'h0008, "R9 mask readback");
        pulse(8'h08);
        expect_read(2'd1, 16'h0000, "R9 masked not pending");
        expect_read(2'd0, 16'h0000, "R9 masked poll empty");
        bus_write(2'd2, 16'h0000);
        expect_read(2'd1, word_for(3), "R9 request kept while masked");
        expect_read(2'd0, word_for(3), "R9 poll after unmask");
        bus_write(2'd3, 16'h0);
    endtask

    task automatic t_level_hold;
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk);
        expect_read(2'd0, word_for(0), "R2 level source acknowledged");
        bus_write(2'd3, 16'h0);
        expect_read(2'd1, 16'h0000, "R2 held level does not re-latch");
        @(negedge clk); irq_in[0] = 1'b0;
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk); irq_in[0] = 1'b0;
        expect_read(2'd1, word_for(0), "R2 new edge latches");
        expect_read(2'd0, word_for(0), "R2 poll new edge");
        bus_write(2'd3, 16'h0);
    endtask

    initial begin
        #(TCLK * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rvalid_window();
        t_single();
        t_priority();
        t_nesting();
        t_empty_poll();
        t_status_noside();
        t_mask();
        t_level_hold();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule